// File: doc/BRIEF.md
# Metaball Field Threshold Renderer

This block produces a one-bit-per-pixel image of a metaball field. It scans a low-resolution frame in row-major order, and for each pixel it works out how strongly every ball influences that point. A ball centred at (cx, cy) with radius r contributes r² divided by its squared distance to the pixel. The renderer adds up all the contributions and lights the pixel when the total is above a fixed threshold. Balls that come close together then merge into one blob.

Each ball has its own evaluation unit, and all units run in parallel, so adding a ball costs area but no frame time. Each unit divides with a serial restoring divider that yields one quotient bit per cycle. The scan controller therefore moves to the next pixel only after every unit reports that it is finished. At that moment it issues one write strobe carrying the pixel index and the pixel's lit bit.

A single start pulse renders one full frame. At the end the renderer emits a one-cycle frame-done pulse and then idles until the next start. Ball positions and radii come from outside. They are expected to be updated between frames.

Top module: `metaball_renderer`

## Requirements
- R1: While reset is asserted and right after its release, `pix_we_o` and `frame_done_o` are low and `pix_addr_o` is zero.
- R2: A start pulse accepted while idle leads to exactly H_PIX*V_PIX write strobes. Their addresses are 0, 1, 2, … in ascending order, where address = y*H_PIX + x (x is the column, y is the row).
- R3: A ball's contribution equals floor(r² · 2^Q / (dx² + dy²)). The value is unsigned fixed point with Q fractional bits, and it saturates at 2^(N+Q) − 1.
- R4: When the pixel coincides with a ball centre (zero distance), that ball's contribution is the saturated maximum, even when the radius is zero. The centre pixel is therefore always lit.
- R5: `pix_bit_o` is 1 on a write when the sum of all contributions is strictly greater than THRESH, and 0 otherwise. A sum exactly equal to THRESH gives 0.
- R6: `frame_done_o` is high for exactly one cycle. That cycle immediately follows the write strobe for address H_PIX*V_PIX − 1, and no write strobe occurs after it until the next start.
- R7: A start pulse that arrives while a frame is in progress has no effect: the address sequence and the write count of the frame are unchanged.
- R8: Within a frame, consecutive write strobes are exactly 2*RW + Q + 2 cycles apart. Each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that begins one frame when the block is idle |
| ball_x_i | input | NUM_BALLS*XW | Column of each ball centre, with ball 0 in the low bits |
| ball_y_i | input | NUM_BALLS*YW | Row of each ball centre, with ball 0 in the low bits |
| ball_r_i | input | NUM_BALLS*RW | Integer radius of each ball, with ball 0 in the low bits |
| pix_we_o | output | 1 | One-cycle write strobe for the current pixel |
| pix_addr_o | output | AW | Linear pixel index, y*H_PIX + x |
| pix_bit_o | output | 1 | Lit bit of the pixel |
| frame_done_o | output | 1 | One-cycle pulse after the last pixel |

## Verification
The assertions assume that start arrives as a short pulse and that the scan never sees a reset in the middle of a frame while a check is pending. They also assume that ball centres lie inside the frame, so every squared distance fits the distance register. The stimulus draws coordinates modulo the frame size and radii modulo a small bound. Ball inputs change only while the block is idle, so the bench's reference image for a frame uses the same values the units sampled. Extra start pulses are injected mid-frame on purpose, to show that they are ignored.

// File: rtl/mb_pkg.sv
package mb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_FIN
  } scan_state_e;
endpackage

// File: rtl/mb_ball_unit.sv
module mb_ball_unit #(
  parameter int CW = 8,
  parameter int RW = 7,
  parameter int Q  = 8,
  parameter int QW = 16,
  parameter int DW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] px_i,
  input  logic [CW-1:0] py_i,
  input  logic [CW-1:0] cx_i,
  input  logic [CW-1:0] cy_i,
  input  logic [RW-1:0] r_i,
  output logic [QW-1:0] contrib_o,
  output logic          done_o
);
  localparam int NW   = 2 * RW + Q;
  localparam int CNTW = $clog2(NW + 1);

  logic [CW-1:0]   dx, dy;
  logic [DW-1:0]   dsq;
  logic [NW-1:0]   num;
  logic [DW-1:0]   div_q, rem_q, rem_n;
  logic [NW-1:0]   quo_q, quo_n;
  logic [DW:0]     trial;
  logic            ge;
  logic [CNTW-1:0] cnt_q;
  logic            busy_q, done_q, zero_q, sat;
  logic [QW-1:0]   res_q;

  always_comb begin
    dx  = (px_i >= cx_i) ? px_i - cx_i : cx_i - px_i;
    dy  = (py_i >= cy_i) ? py_i - cy_i : cy_i - py_i;
    dsq = DW'(dx) * DW'(dx) + DW'(dy) * DW'(dy);
    num = (NW'(r_i) * NW'(r_i)) << Q;
  end

  // one restoring step per cycle
  always_comb begin
    trial = {rem_q, quo_q[NW-1]};
    ge    = trial >= {1'b0, div_q};
    rem_n = ge ? DW'(trial - {1'b0, div_q}) : trial[DW-1:0];
    quo_n = {quo_q[NW-2:0], ge};
  end

  generate
    if (NW > QW) begin : g_wide
      assign sat = zero_q | (|quo_n[NW-1:QW]);
    end else begin : g_narrow
      assign sat = zero_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      zero_q <= 1'b0;
      res_q  <= '0;
    end else if (start_i) begin
      div_q  <= dsq;
      rem_q  <= '0;
      quo_q  <= num;
      cnt_q  <= CNTW'(NW);
      busy_q <= 1'b1;
      done_q <= 1'b0;
      zero_q <= (dsq == '0);
    end else if (busy_q) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        res_q  <= sat ? '1 : quo_n[QW-1:0];
      end
    end
  end

  assign contrib_o = res_q;
  assign done_o    = done_q;
endmodule

// File: rtl/mb_field_sum.sv
module mb_field_sum #(
  parameter int          NB     = 4,
  parameter int          QW     = 16,
  parameter int unsigned THRESH = 256
) (
  input  logic [NB*QW-1:0] contrib_i,
  output logic             lit_o
);
  localparam int SW = QW + $clog2(NB) + 1;

  logic [SW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int b = 0; b < NB; b++) begin
      sum = sum + SW'(contrib_i[b*QW +: QW]);
    end
    lit_o = sum > SW'(THRESH);
  end
endmodule

// File: rtl/mb_scan_ctrl.sv
module mb_scan_ctrl
  import mb_pkg::*;
#(
  parameter int H_PIX = 180,
  parameter int V_PIX = 90,
  parameter int XW    = 8,
  parameter int YW    = 7,
  parameter int AW    = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          all_done_i,
  input  logic          lit_i,
  output logic          unit_start_o,
  output logic [XW-1:0] px_o,
  output logic [YW-1:0] py_o,
  output logic          pix_we_o,
  output logic [AW-1:0] pix_addr_o,
  output logic          pix_bit_o,
  output logic          frame_done_o
);
  scan_state_e   state_q;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [AW-1:0] idx_q;
  logic          last_x, last_px;

  assign last_x  = (x_q == XW'(H_PIX - 1));
  assign last_px = last_x && (y_q == YW'(V_PIX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      x_q          <= '0;
      y_q          <= '0;
      idx_q        <= '0;
      pix_we_o     <= 1'b0;
      pix_addr_o   <= '0;
      pix_bit_o    <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      pix_we_o     <= 1'b0;
      frame_done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          x_q     <= '0;
          y_q     <= '0;
          idx_q   <= '0;
          state_q <= ST_LAUNCH;
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: if (all_done_i) begin
          pix_we_o   <= 1'b1;
          pix_addr_o <= idx_q;
          pix_bit_o  <= lit_i;
          if (last_px) begin
            state_q <= ST_FIN;
          end else begin
            idx_q   <= idx_q + 1'b1;
            x_q     <= last_x ? '0 : x_q + 1'b1;
            y_q     <= last_x ? y_q + 1'b1 : y_q;
            state_q <= ST_LAUNCH;
          end
        end
        ST_FIN: begin
          frame_done_o <= 1'b1;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign unit_start_o = (state_q == ST_LAUNCH);
  assign px_o         = x_q;
  assign py_o         = y_q;
endmodule

// File: rtl/metaball_renderer.sv
module metaball_renderer #(
  parameter int          H_PIX     = 180,
  parameter int          V_PIX     = 90,
  parameter int          NUM_BALLS = 4,
  parameter int          RW        = 7,
  parameter int          N         = 8,
  parameter int          Q         = 8,
  parameter int unsigned THRESH    = 1 << Q,
  localparam int         XW        = $clog2(H_PIX),
  localparam int         YW        = $clog2(V_PIX),
  localparam int         PIX       = H_PIX * V_PIX,
  localparam int         AW        = $clog2(PIX)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [NUM_BALLS*XW-1:0] ball_x_i,
  input  logic [NUM_BALLS*YW-1:0] ball_y_i,
  input  logic [NUM_BALLS*RW-1:0] ball_r_i,
  output logic                    pix_we_o,
  output logic [AW-1:0]           pix_addr_o,
  output logic                    pix_bit_o,
  output logic                    frame_done_o
);
  localparam int CW = (XW > YW) ? XW : YW;
  localparam int DW = 2 * CW + 1;  // holds dx^2 + dy^2 without overflow
  localparam int QW = N + Q;

  logic                    unit_start, lit;
  logic [XW-1:0]           px;
  logic [YW-1:0]           py;
  logic [NUM_BALLS-1:0]    done_vec;
  logic [NUM_BALLS*QW-1:0] contrib;

  mb_scan_ctrl #(
    .H_PIX(H_PIX), .V_PIX(V_PIX), .XW(XW), .YW(YW), .AW(AW)
  ) u_scan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .all_done_i   (&done_vec),
    .lit_i        (lit),
    .unit_start_o (unit_start),
    .px_o         (px),
    .py_o         (py),
    .pix_we_o     (pix_we_o),
    .pix_addr_o   (pix_addr_o),
    .pix_bit_o    (pix_bit_o),
    .frame_done_o (frame_done_o)
  );

  for (genvar b = 0; b < NUM_BALLS; b++) begin : g_ball
    mb_ball_unit #(
      .CW(CW), .RW(RW), .Q(Q), .QW(QW), .DW(DW)
    ) u_unit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (unit_start),
      .px_i      (CW'(px)),
      .py_i      (CW'(py)),
      .cx_i      (CW'(ball_x_i[b*XW +: XW])),
      .cy_i      (CW'(ball_y_i[b*YW +: YW])),
      .r_i       (ball_r_i[b*RW +: RW]),
      .contrib_o (contrib[b*QW +: QW]),
      .done_o    (done_vec[b])
    );
  end

  mb_field_sum #(
    .NB(NUM_BALLS), .QW(QW), .THRESH(THRESH)
  ) u_sum (
    .contrib_i (contrib),
    .lit_o     (lit)
  );
endmodule

// File: rtl/mb_renderer_chk.sv
module mb_renderer_chk #(
  parameter int AW  = 14,
  parameter int PIX = 16200
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pix_we_i,
  input logic [AW-1:0] pix_addr_i,
  input logic          frame_done_i
);
  logic [AW-1:0] exp_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          exp_addr_q <= '0;
    else if (frame_done_i) exp_addr_q <= '0;
    else if (pix_we_i)     exp_addr_q <= pix_addr_i + 1'b1;
  end

  AST_ADDR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_we_i |-> pix_addr_i == exp_addr_q);  // R2
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_we_i |-> pix_addr_i <= AW'(PIX - 1));  // R2
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_we_i |=> !pix_we_i);  // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> !frame_done_i);  // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |-> $past(pix_we_i) && $past(pix_addr_i) == AW'(PIX - 1));  // R6
  AST_NO_WE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |-> !pix_we_i);  // R6
endmodule

bind metaball_renderer mb_renderer_chk #(.AW(AW), .PIX(PIX)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pix_we_i     (pix_we_o),
  .pix_addr_i   (pix_addr_o),
  .frame_done_i (frame_done_o)
);

// File: tb/tb_metaball_renderer.sv
`timescale 1ns/1ps
module tb_metaball_renderer;
  localparam int H   = 12;
  localparam int V   = 8;
  localparam int NB  = 3;
  localparam int RW  = 5;
  localparam int N   = 6;
  localparam int Q   = 4;
  localparam int TH  = 16;
  localparam int XW  = $clog2(H);
  localparam int YW  = $clog2(V);
  localparam int PIX = H * V;
  localparam int AW  = $clog2(PIX);
  localparam int MAXV = (1 << (N + Q)) - 1;
  localparam int PERIOD = 2 * RW + Q + 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [NB*XW-1:0] bx_v;
  logic [NB*YW-1:0] by_v;
  logic [NB*RW-1:0] br_v;
  logic we, pbit, fdone;
  logic [AW-1:0] addr;

  int bx[NB], by[NB], br[NB];
  int checks = 0, fails = 0;
  int cyc = 0, last_we_cyc = -1, exp_addr = 0, writes = 0, dones = 0;
  bit mon_on = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int b = 0; b < NB; b++) begin
      bx_v[b*XW +: XW] = XW'(bx[b]);
      by_v[b*YW +: YW] = YW'(by[b]);
      br_v[b*RW +: RW] = RW'(br[b]);
    end

  metaball_renderer #(
    .H_PIX(H), .V_PIX(V), .NUM_BALLS(NB), .RW(RW), .N(N), .Q(Q), .THRESH(TH)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ball_x_i(bx_v), .ball_y_i(by_v), .ball_r_i(br_v),
    .pix_we_o(we), .pix_addr_o(addr), .pix_bit_o(pbit), .frame_done_o(fdone)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int contrib(int b, int px, int py);
    int d, q;
    d = (px - bx[b]) * (px - bx[b]) + (py - by[b]) * (py - by[b]);
    if (d == 0) return MAXV;
    q = ((br[b] * br[b]) << Q) / d;
    return (q > MAXV) ? MAXV : q;
  endfunction

  function automatic bit at_centre(int px, int py);
    for (int b = 0; b < NB; b++) if (bx[b] == px && by[b] == py) return 1;
    return 0;
  endfunction

  function automatic bit exp_bit(int idx);
    int s = 0;
    for (int b = 0; b < NB; b++) s += contrib(b, idx % H, idx / H);
    return s > TH;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (we) begin
        check(int'(addr) == exp_addr, "R2 address order", int'(addr), exp_addr);
        if (at_centre(int'(addr) % H, int'(addr) / H))
          check(pbit == 1'b1, "R4 centre lit", int'(pbit), 1);
        else
          check(pbit == exp_bit(int'(addr)), "R3/R5 pixel bit", int'(pbit), int'(exp_bit(int'(addr))));
        if (last_we_cyc >= 0)
          check(cyc - last_we_cyc == PERIOD, "R8 strobe spacing", cyc - last_we_cyc, PERIOD);
        last_we_cyc = cyc;
        exp_addr++;
        writes++;
      end
      if (fdone) begin
        dones++;
        check(last_we_cyc == cyc - 1 && exp_addr == PIX, "R6 done after last write",
              exp_addr, PIX);
        last_we_cyc = -1;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic run_frame(bit poke_mid);
    exp_addr = 0; writes = 0; dones = 0; last_we_cyc = -1;
    mon_on = 1;
    pulse_start();
    if (poke_mid) begin
      repeat (PIX * PERIOD / 2) @(negedge clk);
      pulse_start();  // R7: must be ignored
    end
    while (dones == 0) @(negedge clk);
    @(negedge clk);
    check(!fdone, "R6 done one cycle", int'(fdone), 0);
    repeat (3 * PERIOD) @(negedge clk);
    check(writes == PIX, poke_mid ? "R7 write count" : "R2 write count", writes, PIX);
    check(dones == 1, "R6 done count", dones, 1);
    mon_on = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int b = 0; b < NB; b++) begin bx[b] = 0; by[b] = 0; br[b] = 0; end
    repeat (4) @(negedge clk);
    check(!we && !fdone && addr == '0, "R1 reset state", int'(we) + int'(fdone) + int'(addr), 0);
    rst_n = 1;
    @(negedge clk);
    check(!we && !fdone && addr == '0, "R1 after release", int'(we) + int'(fdone) + int'(addr), 0);

    // directed: zero radius at a centre, equal-to-threshold ring, corner ball
    bx[0] = 3; by[0] = 2; br[0] = 0;
    bx[1] = 8; by[1] = 5; br[1] = 2;
    bx[2] = 0; by[2] = 7; br[2] = 3;
    run_frame(0);

    // R7 with an extra start mid-frame
    bx[0] = 6; by[0] = 4; br[0] = 4;
    run_frame(1);

    for (int f = 0; f < 3; f++) begin
      for (int b = 0; b < NB; b++) begin
        bx[b] = int'($urandom % H);
        by[b] = int'($urandom % V);
        br[b] = int'($urandom % 8);
      end
      run_frame(0);
    end

    // only centres can be lit
    for (int b = 0; b < NB; b++) br[b] = 0;
    bx[0] = H - 1; by[0] = V - 1;
    run_frame(0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule